// File: doc/BRIEF.md
# Per-Core Countdown Timer

This block is a 32-bit down-counting timer that sits beside a per-core interrupt controller. Software programs it through a small register port: a timer control entry holding the interrupt vector, a mask bit and a mode bit, a start value, a clock-divide setting, and the live count. After a start value is written, the live count drops by one every time the divided clock ticks. When the count runs out, the timer raises a one-cycle interrupt request with the programmed vector, unless the entry is masked.

In one-shot mode the count stops at zero, so software can poll the live count until it reads zero. In periodic mode the live count is refilled from the start value at every expiry, which gives a steady train of requests. A pending flag records each delivered request. It stays set until the acceptance logic downstream pulses the accept input. The live count may be rewritten at any time, including while the timer is running.

Top module: `core_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide setting, the start value and the live count all read 0, and `irq_pulse` and `irq_pending` are low.
- R2: The port selects a register by `bus_addr`: 0 is the control entry, 1 is the start value, 2 is the live count and 3 is the divide setting. In the control entry, bits 7:0 are the vector, bit 16 is the mask and bit 17 selects periodic (1) or one-shot (0). Bit 12 reads back the pending flag and cannot be written. A read issued with `bus_sel` high and `bus_wr` low appears on `bus_rdata` after the next clock edge, and it returns the register value just before that edge.
- R3: Only divide-setting bits 0, 1 and 3 are stored; the other bits read as 0. The stored code {b3,b1,b0} selects the ratio: 000→/2, 001→/4, 010→/8, 011→/16, 100→/32, 101→/64, 110→/128, 111→/1. For example, code 0x4 acts as /2 and writing 0xF reads back 0xB.
- R4: Writing a nonzero start value N loads the live count and restarts the divider at the active ratio R. `irq_pulse` is then high in the cycle that follows the edge N×R edges after the write edge.
- R5: In one-shot mode the live count reaches zero at expiry and stays at zero.
- R6: In periodic mode each expiry reloads the live count from the start value, so unmasked pulses repeat every N×R cycles.
- R7: While the mask bit is set, an expiry produces no pulse and does not set pending, but the count still runs down to zero.
- R8: Writing a start value of 0 stops the timer with the live count at 0, and no interrupt follows.
- R9: `irq_pulse` lasts one cycle per expiry, and `irq_vector` carries the programmed vector in that same cycle. `irq_pending` rises with the pulse and stays high until `irq_accept` is seen high.
- R10: A new divide setting takes effect at the next divider boundary and leaves the live count untouched.
- R11: A write to the live count replaces its value without restarting the divider, and counting carries on from that value. Writing 0 stops the timer without an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_accept | input | 1 | Clears the pending flag |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest delivered request |
| irq_pending | output | 1 | Request delivered, not yet accepted |

## Verification
A wrong divider state moves the expiry pulse by whole multiples of the ratio, so it shows up within N×R cycles of a start-value write as a pulse at the wrong cycle. A wrong count or reload state shows as a wrong live-count readback two cycles after a write, as a periodic gap of the wrong length, or as a pulse that escapes through the mask. A wrong pending state shows on `irq_pending` and on control-entry bit 12 in the cycle after an expiry or an accept.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned SHIFT_W      = 3;
  localparam int unsigned ENT_PEND_BIT = 12;
  localparam int unsigned ENT_MASK_BIT = 16;
  localparam int unsigned ENT_PER_BIT  = 17;

  typedef enum logic [1:0] {
    REG_ENTRY = 2'd0,
    REG_INIT  = 2'd1,
    REG_CUR   = 2'd2,
    REG_DIV   = 2'd3
  } reg_sel_e;

  // compressed code {b3,b1,b0} -> log2 of ratio; 111 wraps to /1
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] idx);
    return SHIFT_W'(idx) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             pending,
  input  logic [CNT_W-1:0] cur,
  output logic [VEC_W-1:0] vector,
  output logic             mask,
  output logic             periodic,
  output logic [CNT_W-1:0] init_q,
  output logic [2:0]       div_idx,
  output logic             init_wr,
  output logic             cur_wr,
  output logic [BUS_W-1:0] rdata
);
  logic             wr_hit;
  logic [BUS_W-1:0] rd_mux;

  assign wr_hit  = sel & wr;
  assign init_wr = wr_hit && (reg_sel_e'(addr) == REG_INIT);
  assign cur_wr  = wr_hit && (reg_sel_e'(addr) == REG_CUR);

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(addr))
      REG_ENTRY: begin
        rd_mux[VEC_W-1:0]   = vector;
        rd_mux[ENT_PEND_BIT] = pending;
        rd_mux[ENT_MASK_BIT] = mask;
        rd_mux[ENT_PER_BIT]  = periodic;
      end
      REG_INIT: rd_mux[CNT_W-1:0] = init_q;
      REG_CUR:  rd_mux[CNT_W-1:0] = cur;
      default: begin
        rd_mux[3]   = div_idx[2];
        rd_mux[1:0] = div_idx[1:0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vector   <= '0;
      mask     <= 1'b1;
      periodic <= 1'b0;
      init_q   <= '0;
      div_idx  <= '0;
      rdata    <= '0;
    end else begin
      if (wr_hit && reg_sel_e'(addr) == REG_ENTRY) begin
        vector   <= wdata[VEC_W-1:0];
        mask     <= wdata[ENT_MASK_BIT];
        periodic <= wdata[ENT_PER_BIT];
      end
      if (init_wr) init_q <= wdata[CNT_W-1:0];
      if (wr_hit && reg_sel_e'(addr) == REG_DIV)
        div_idx <= {wdata[3], wdata[1:0]};
      if (sel && !wr) rdata <= rd_mux;
    end
  end

  // R3
  div_store_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr && reg_sel_e'(addr) == REG_DIV) |=> (rdata[2] == 1'b0 && rdata[BUS_W-1:4] == '0));
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler
  import ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] div_idx,
  output logic       tick
);
  localparam int PW = (1 << SHIFT_W) - 1;

  logic [PW-1:0]      cnt;
  logic [SHIFT_W-1:0] act_shift;
  logic [PW:0]        limit;

  assign limit = (({{PW{1'b0}}, 1'b1}) << act_shift) - 1'b1;
  assign tick  = ({1'b0, cnt} == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act_shift <= div_shift(3'd0);
    end else if (restart || tick) begin
      cnt       <= '0;
      act_shift <= div_shift(div_idx);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  prs_range_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt} <= limit));
  // R10
  prs_ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !tick) |=> $stable(act_shift));
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_init,
  input  logic             load_cur,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_hold,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic quiet;
  assign quiet  = !load_init && !load_cur;
  assign expire = quiet && tick && (cur == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load_init || load_cur) begin
      cur <= load_val;
    end else if (tick && cur != '0) begin
      if (cur == ONE) cur <= periodic ? init_hold : '0;
      else            cur <= cur - ONE;
    end
  end

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && cur == '0) |=> (cur == '0));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && cur > ONE) |=> (cur == $past(cur) || cur == $past(cur) - ONE));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic) |=> (cur == $past(init_hold)));
endmodule

// File: rtl/core_countdown_timer.sv
module core_countdown_timer
  import ct_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             irq_accept,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_pending
);
  logic [VEC_W-1:0] vector;
  logic             mask, periodic, init_wr, cur_wr, tick, expire, fire;
  logic [CNT_W-1:0] init_q, cur;
  logic [2:0]       div_idx;

  ct_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .pending(irq_pending), .cur(cur),
    .vector(vector), .mask(mask), .periodic(periodic), .init_q(init_q),
    .div_idx(div_idx), .init_wr(init_wr), .cur_wr(cur_wr), .rdata(bus_rdata)
  );

  ct_prescaler u_prs (
    .clk(clk), .rst(rst), .restart(init_wr), .div_idx(div_idx), .tick(tick)
  );

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_init(init_wr), .load_cur(cur_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .init_hold(init_q), .periodic(periodic),
    .cur(cur), .expire(expire)
  );

  assign fire = expire & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse   <= 1'b0;
      irq_vector  <= '0;
      irq_pending <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire) irq_vector <= vector;
      if (fire)            irq_pending <= 1'b1;
      else if (irq_accept) irq_pending <= 1'b0;
    end
  end

  // R7
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(!mask));
  // R9
  pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_pending);
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_pending && !irq_accept) |=> irq_pending);
  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (init_wr && bus_wdata[CNT_W-1:0] == '0) |=> !irq_pulse);
endmodule

// File: tb/core_countdown_timer_test.sv
`timescale 1ns/1ps
module core_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, irq_accept = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_pulse, irq_pending;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  core_countdown_timer uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_accept(irq_accept), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector), .irq_pending(irq_pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_pulse(input int lim, output int k, output logic [7:0] v);
    int n = 0;
    k = -1; v = 8'h00;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (irq_pulse) begin k = n; v = irq_vector; break; end
    end
  endtask

  task automatic accept_irq();
    @(negedge clk); irq_accept = 1'b1;
    @(negedge clk); irq_accept = 1'b0;
  endtask

  function automatic int ratio_of(input logic [3:0] code);
    case ({code[3], code[1], code[0]})
      3'b000: return 2;   3'b001: return 4;
      3'b010: return 8;   3'b011: return 16;
      3'b100: return 32;  3'b101: return 64;
      3'b110: return 128; default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] entry(input bit per, input bit msk, input logic [7:0] vec);
    return {14'd0, per, msk, 8'd0, vec};
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  v;
    int          k;
    logic [3:0]  codes [8];
    void'($urandom(32'd4242));
    codes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB};

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pulse", {31'd0, irq_pulse}, 32'd0);
    chk("R1 pending", {31'd0, irq_pending}, 32'd0);
    rd_reg(2'd0, rd); chk("R1 entry", rd, 32'h0001_0000);
    rd_reg(2'd1, rd); chk("R1 init", rd, 32'd0);
    rd_reg(2'd2, rd); chk("R1 cur", rd, 32'd0);
    rd_reg(2'd3, rd); chk("R1 div", rd, 32'd0);

    // R2 entry readback, pending bit not writable
    wr_reg(2'd0, entry(1'b1, 1'b0, 8'h5A) | 32'h0000_1000);
    rd_reg(2'd0, rd); chk("R2 entry rb", rd, 32'h0002_005A);

    // R3 only bits 0,1,3 kept
    wr_reg(2'd3, 32'h0000_000F);
    rd_reg(2'd3, rd); chk("R3 div rb", rd, 32'h0000_000B);

    // R4 start at default /2: live count right after write, then timing
    wr_reg(2'd0, entry(1'b0, 1'b0, 8'h31));
    wr_reg(2'd3, 32'h0);
    wr_reg(2'd1, 32'd7);
    rd_reg(2'd2, rd); chk("R4 cur after start", rd, 32'd7);
    wr_reg(2'd1, 32'd3);
    wait_pulse(100, k, v); chk("R4 pulse time /2", k, 32'd6);
    chk("R9 vector", {24'd0, v}, 32'h31);
    @(negedge clk); chk("R9 single cycle", {31'd0, irq_pulse}, 32'd0);
    // R5 stays zero
    rd_reg(2'd2, rd); chk("R5 cur zero", rd, 32'd0);
    wait_pulse(40, k, v); chk("R5 no second pulse", k, 32'hFFFF_FFFF);
    // R9 pending until accept
    chk("R9 pending set", {31'd0, irq_pending}, 32'd1);
    rd_reg(2'd0, rd); chk("R9 entry bit12", {31'd0, rd[12]}, 32'd1);
    accept_irq();
    chk("R9 pending cleared", {31'd0, irq_pending}, 32'd0);

    // R3 code 0x4 acts as /2
    wr_reg(2'd3, 32'h4);
    wr_reg(2'd1, 32'd5);
    wait_pulse(100, k, v); chk("R3 code4 time", k, 32'd10);
    accept_irq();

    // R6 periodic gap
    wr_reg(2'd0, entry(1'b1, 1'b0, 8'h77));
    wr_reg(2'd3, 32'h1);
    wr_reg(2'd1, 32'd3);
    wait_pulse(100, k, v); chk("R6 first", k, 32'd12);
    wait_pulse(100, k, v); chk("R6 gap", k, 32'd12);
    wait_pulse(100, k, v); chk("R6 gap2", k, 32'd12);
    chk("R6 vector", {24'd0, v}, 32'h77);
    // R8 zero start stops
    wr_reg(2'd1, 32'd0);
    wait_pulse(60, k, v); chk("R8 no pulse", k, 32'hFFFF_FFFF);
    rd_reg(2'd2, rd); chk("R8 cur zero", rd, 32'd0);
    accept_irq();

    // R7 mask: no pulse, counting continues
    wr_reg(2'd0, entry(1'b0, 1'b1, 8'h10));
    wr_reg(2'd3, 32'hB);
    wr_reg(2'd1, 32'd3);
    wait_pulse(12, k, v); chk("R7 masked pulse", k, 32'hFFFF_FFFF);
    chk("R7 masked pending", {31'd0, irq_pending}, 32'd0);
    rd_reg(2'd2, rd); chk("R7 counted to zero", rd, 32'd0);

    // R11 live count write while running
    wr_reg(2'd0, entry(1'b0, 1'b0, 8'hC3));
    wr_reg(2'd1, 32'd1000);
    wr_reg(2'd2, 32'd5);
    wait_pulse(50, k, v); chk("R11 resume from written", k, 32'd5);
    accept_irq();
    wr_reg(2'd1, 32'd1000);
    wr_reg(2'd2, 32'd0);
    wait_pulse(30, k, v); chk("R11 zero write stops", k, 32'hFFFF_FFFF);
    rd_reg(2'd2, rd); chk("R11 cur zero", rd, 32'd0);

    // R10 divide change at next boundary, no count reset
    wr_reg(2'd1, 32'd50);
    wr_reg(2'd3, 32'hA);
    rd_reg(2'd2, rd); chk("R10 count kept", rd, 32'd47);
    rd_reg(2'd2, rd); chk("R10 new ratio", rd, 32'd47);
    wr_reg(2'd1, 32'd0);

    // random one-shot runs, R4 timing over all ratios
    for (int i = 0; i < 24; i++) begin
      logic [3:0] c = codes[$urandom % 8];
      int         n = 1 + ($urandom % 12);
      logic [7:0] vec = 8'($urandom);
      wr_reg(2'd0, entry(1'b0, 1'b0, vec));
      wr_reg(2'd3, {28'd0, c});
      wr_reg(2'd1, n);
      wait_pulse(n * ratio_of(c) + 10, k, v);
      chk("R4 random time", k, n * ratio_of(c));
      chk("R9 random vector", {24'd0, v}, {24'd0, vec});
      accept_irq();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule